// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block picks the next fetch address for a 32-bit little-endian RISC core in which every control transfer has one architectural delay slot. Each cycle it receives the fetched instruction word, that word's address, the condition-code flag and the value read from the register file for the register named in the instruction. It decodes six direct transfer forms (unconditional branch, call, branch on CC set and branch on CC clear, the two conditional forms each with and without a static taken hint) and one register-indirect branch.

A taken transfer never redirects fetch at once. The branch cycle still steps to the next sequential word, the delay slot. The computed target is held in a one-entry pending-redirect register and becomes the next PC while the delay-slot instruction is presented. A call also asks for the return address to be written to the link register. The instruction stream has no back-pressure: `fetch_en` acts as the valid strobe, the block accepts a word in every enabled cycle, and it never stalls fetch, so it has no ready output. While `fetch_en` is low the pending state holds and no taken, link or slot-conflict indication is raised.

Top module: `nextpc_unit`

## Requirements
- R1: An active-low asynchronous reset clears the pending redirect at once. After reset a non-transfer word at address A gives next_pc = A+4.
- R2: A word whose opcode (bits 31:26) is none of 0x10, 0x1a to 0x1f gives taken = 0, hint = 0, link_we = 0 and next_pc = pc+4.
- R3: Opcodes 0x1a (branch) and 0x1b (call) are always taken. The target is pc+4 plus the sign-extended bits 25:0 multiplied by 4. In the branch cycle next_pc = pc+4. In the next enabled cycle, the delay slot, next_pc is the target.
- R4: Opcode 0x1b asserts link_we with link_addr = 1 and link_data = pc+8 in its own cycle. No other opcode asserts link_we.
- R5: Opcode 0x1c is taken only when cc_flag = 1. Opcode 0x1e is taken only when cc_flag = 0. An untaken branch leaves the delay slot with next_pc = its own pc+4.
- R6: Opcodes 0x1d and 0x1f take the same conditions as 0x1c and 0x1e and also drive hint = 1, whether or not they are taken.
- R7: Opcode 0x10 puts bits 15:11 on rf_raddr and is always taken. Its target is rf_rdata with bits 1:0 forced to 0.
- R8: A transfer word presented in a delay slot is not taken and writes no link. slot_xfer = 1, and next_pc is still the first branch's target.
- R9: The pending redirect changes only in cycles with fetch_en = 1. With fetch_en = 0, taken and link_we stay 0, a branch word leaves no redirect, and a pending target stays on next_pc.
- R10: The extreme displacements 0x1FFFFFF (+0x7FFFFFC bytes) and 0x2000000 (-0x8000000 bytes) reach the correct targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_en | input | 1 | Instruction valid / fetch advance |
| instr | input | 32 | Fetched instruction word |
| pc | input | 32 | Address of instr |
| cc_flag | input | 1 | Condition-code flag |
| rf_raddr | output | 5 | Register index for the indirect target |
| rf_rdata | input | 32 | Register value for rf_raddr |
| next_pc | output | 32 | Next fetch address |
| taken | output | 1 | This word is a taken control transfer |
| hint | output | 1 | Static taken-hint of this word |
| link_we | output | 1 | Link register write request |
| link_addr | output | 5 | Link register index |
| link_data | output | 32 | Return address to write |
| slot_xfer | output | 1 | Transfer found in a delay slot (suppressed) |

## Verification
Each transfer opcode is run as a branch word followed by a plain delay-slot word. Checking next_pc in both cycles separates a correct one-slot delay from an immediate redirect or a lost redirect. Every conditional form is run with the flag set and with it clear, with targets chosen away from pc+8, so that an inverted condition or an ignored hint shows up. Indirect targets with unaligned low bits and several register indices, plus the two extreme displacements, exercise masking, field extraction and sign extension. Directed sequences cover a branch in a delay slot, fetch stalls around a pending redirect, and reset while a redirect is pending.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  localparam logic [5:0] OP_JMPR  = 6'h10;
  localparam logic [5:0] OP_JMP   = 6'h1a;
  localparam logic [5:0] OP_JAL   = 6'h1b;
  localparam logic [5:0] OP_BSET  = 6'h1c;
  localparam logic [5:0] OP_BSETH = 6'h1d;
  localparam logic [5:0] OP_BCLR  = 6'h1e;
  localparam logic [5:0] OP_BCLRH = 6'h1f;

  typedef struct packed {
    logic is_ctrl;
    logic indirect;
    logic is_call;
    logic need_cc;
    logic cc_pol;
    logic hint;
  } xfer_dec_t;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import nextpc_pkg::*;
#(
  parameter int OPW = 6
) (
  input  logic [OPW-1:0] opcode,
  output xfer_dec_t      dec
);

  always_comb begin
    dec = '0;
    unique case (opcode)
      OP_JMPR:  begin dec.is_ctrl = 1'b1; dec.indirect = 1'b1; end
      OP_JMP:   begin dec.is_ctrl = 1'b1; end
      OP_JAL:   begin dec.is_ctrl = 1'b1; dec.is_call = 1'b1; end
      OP_BSET:  begin dec.is_ctrl = 1'b1; dec.need_cc = 1'b1; dec.cc_pol = 1'b1; end
      OP_BSETH: begin dec.is_ctrl = 1'b1; dec.need_cc = 1'b1; dec.cc_pol = 1'b1;
                      dec.hint = 1'b1; end
      OP_BCLR:  begin dec.is_ctrl = 1'b1; dec.need_cc = 1'b1; end
      OP_BCLRH: begin dec.is_ctrl = 1'b1; dec.need_cc = 1'b1; dec.hint = 1'b1; end
      default:  dec = '0;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN  = 32,
  parameter int DISPW = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [DISPW-1:0] disp,
  input  logic [XLEN-1:0]  reg_val,
  input  logic             indirect,
  output logic [XLEN-1:0]  target
);

  localparam int SHIFT = 2;
  localparam int EXTW  = XLEN - DISPW - SHIFT;
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  logic [XLEN-1:0] byte_off;
  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] abs_tgt;

  assign byte_off = {{EXTW{disp[DISPW-1]}}, disp, {SHIFT{1'b0}}};
  assign rel_tgt  = pc + STEP + byte_off;
  assign abs_tgt  = {reg_val[XLEN-1:SHIFT], {SHIFT{1'b0}}};
  assign target   = indirect ? abs_tgt : rel_tgt;

endmodule

// File: rtl/npc_redirect.sv
module npc_redirect #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            arm,
  input  logic [XLEN-1:0] tgt_in,
  output logic            pend_valid,
  output logic [XLEN-1:0] pend_tgt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_tgt   <= '0;
    end else if (advance) begin
      pend_valid <= arm;
      pend_tgt   <= tgt_in;
    end
  end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int DISPW    = 26,
  parameter int REGW     = 5,
  parameter int RIDX_LSB = 11,
  parameter int LINK_REG = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_en,
  input  logic [31:0]     instr,
  input  logic [31:0]     pc,
  input  logic            cc_flag,
  output logic [4:0]      rf_raddr,
  input  logic [31:0]     rf_rdata,
  output logic [31:0]     next_pc,
  output logic            taken,
  output logic            hint,
  output logic            link_we,
  output logic [4:0]      link_addr,
  output logic [31:0]     link_data,
  output logic            slot_xfer
);

  localparam int OPW = XLEN - DISPW;
  localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

  xfer_dec_t       dec;
  logic [XLEN-1:0] target;
  logic            pend_valid;
  logic [XLEN-1:0] pend_tgt;
  logic            cond_ok;
  logic            take_raw;

  npc_decode #(.OPW(OPW)) u_dec (
    .opcode (instr[XLEN-1:DISPW]),
    .dec    (dec)
  );

  npc_target #(.XLEN(XLEN), .DISPW(DISPW)) u_tgt (
    .pc       (pc),
    .disp     (instr[DISPW-1:0]),
    .reg_val  (rf_rdata),
    .indirect (dec.indirect),
    .target   (target)
  );

  npc_redirect #(.XLEN(XLEN)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (fetch_en),
    .arm        (take_raw),
    .tgt_in     (target),
    .pend_valid (pend_valid),
    .pend_tgt   (pend_tgt)
  );

  // Condition: unconditional forms pass; conditional ones compare the flag.
  assign cond_ok  = !dec.need_cc || (cc_flag == dec.cc_pol);
  // A transfer sitting in a delay slot is suppressed.
  assign take_raw = dec.is_ctrl && cond_ok && !pend_valid;

  assign rf_raddr  = instr[RIDX_LSB +: REGW];
  assign taken     = fetch_en && take_raw;
  assign hint      = dec.hint && !pend_valid;
  assign link_we   = fetch_en && dec.is_call && !pend_valid;
  assign link_addr = REGW'(LINK_REG);
  assign link_data = pc + (STEP << 1);
  assign slot_xfer = fetch_en && pend_valid && dec.is_ctrl;
  assign next_pc   = pend_valid ? pend_tgt : pc + STEP;

endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_en,
  input logic [31:0] instr,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic        taken,
  input logic        hint,
  input logic        link_we,
  input logic [4:0]  link_addr,
  input logic [31:0] link_data,
  input logic        slot_xfer,
  input logic        pend_valid
);

  assert_delay_slot_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> next_pc == pc + 32'd4);

  assert_link_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_addr == 5'd1 && link_data == pc + 32'd8 && instr[31:26] == 6'h1b));

  assert_hint_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hint |-> (instr[31:26] == 6'h1d || instr[31:26] == 6'h1f));

  assert_slot_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_xfer |-> (!taken && !link_we));

  assert_slot_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && pend_valid) |=> !pend_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> $stable(pend_valid));

  assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |-> (!taken && !link_we && !slot_xfer));

endmodule

bind nextpc_unit nextpc_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fetch_en   (fetch_en),
  .instr      (instr),
  .pc         (pc),
  .next_pc    (next_pc),
  .taken      (taken),
  .hint       (hint),
  .link_we    (link_we),
  .link_addr  (link_addr),
  .link_data  (link_data),
  .slot_xfer  (slot_xfer),
  .pend_valid (pend_valid)
);

// File: tb/nextpc_unit_test.sv
`timescale 1ns/1ps
module nextpc_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_en = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] pc = '0;
  logic        cc_flag = 1'b0;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata = '0;
  logic [31:0] next_pc;
  logic        taken, hint, link_we, slot_xfer;
  logic [4:0]  link_addr;
  logic [31:0] link_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nextpc_unit uut (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .instr(instr), .pc(pc),
    .cc_flag(cc_flag), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .next_pc(next_pc), .taken(taken), .hint(hint), .link_we(link_we),
    .link_addr(link_addr), .link_data(link_data), .slot_xfer(slot_xfer)
  );

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] pc;
    logic [31:0] rf;
    logic [31:0] after;
    logic        cc;
    logic        tk;
    logic        hn;
    logic        lk;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{32'h68000003, 32'h00001000, 32'h0, 32'h00001010, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 branch
    '{32'h6FFFFFFE, 32'h00002000, 32'h0, 32'h00001FFC, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 call back
    '{32'h70000004, 32'h00003000, 32'h0, 32'h00003014, 1'b1, 1'b1, 1'b0, 1'b0}, // R5 set, cc=1
    '{32'h70000004, 32'h00003000, 32'h0, 32'h00003008, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 set, cc=0
    '{32'h78000008, 32'h00004000, 32'h0, 32'h00004024, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 clr, cc=0
    '{32'h78000008, 32'h00004000, 32'h0, 32'h00004008, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 clr, cc=1
    '{32'h74000002, 32'h00005000, 32'h0, 32'h0000500C, 1'b1, 1'b1, 1'b1, 1'b0}, // R6 hinted set
    '{32'h74000002, 32'h00005000, 32'h0, 32'h00005008, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 hinted, untaken
    '{32'h7C000010, 32'h00006000, 32'h0, 32'h00006044, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 hinted clr
    '{32'h7C000010, 32'h00006000, 32'h0, 32'h00006008, 1'b1, 1'b0, 1'b1, 1'b0}, // R6 hinted, untaken
    '{32'h40000800, 32'h00007000, 32'h00ABCDEF, 32'h00ABCDEC, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 r1
    '{32'h4000F800, 32'h00007100, 32'h12345678, 32'h12345678, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 r31
    '{32'h69FFFFFF, 32'h10000000, 32'h0, 32'h18000000, 1'b0, 1'b1, 1'b0, 1'b0}, // R10 max +
    '{32'h6A000000, 32'h10000000, 32'h0, 32'h08000004, 1'b0, 1'b1, 1'b0, 1'b0}, // R10 max -
    '{32'h48000000, 32'h00008000, 32'h0, 32'h00008008, 1'b1, 1'b0, 1'b0, 1'b0}  // R2 plain word
  };

  localparam logic [31:0] NOP = 32'h00000000;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] w, input logic [31:0] a, input logic c,
                       input logic [31:0] r, input logic en);
    instr = w; pc = a; cc_flag = c; rf_rdata = r; fetch_en = en;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state: no redirect pending
    drive(NOP, 32'h00000100, 1'b0, 32'h0, 1'b1);
    chk("R1 next_pc after reset", next_pc, 32'h00000104);
    chk("R1 taken after reset", {31'b0, taken}, 32'h0);
    tick();

    // Table: branch word, then a plain delay-slot word
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].instr, TBL[i].pc, TBL[i].cc, TBL[i].rf, 1'b1);
      $display("vector %0d (R2 R3 R4 R5 R6 R7 R10)", i);
      chk("R3 branch cycle next_pc", next_pc, TBL[i].pc + 32'd4);
      chk("R5 taken", {31'b0, taken}, {31'b0, TBL[i].tk});
      chk("R6 hint", {31'b0, hint}, {31'b0, TBL[i].hn});
      chk("R4 link_we", {31'b0, link_we}, {31'b0, TBL[i].lk});
      if (TBL[i].lk) begin
        chk("R4 link_addr", {27'b0, link_addr}, 32'd1);
        chk("R4 link_data", link_data, TBL[i].pc + 32'd8);
      end
      if (TBL[i].instr[31:26] == 6'h10)
        chk("R7 rf_raddr", {27'b0, rf_raddr}, {27'b0, TBL[i].instr[15:11]});
      tick();
      drive(NOP, TBL[i].pc + 32'd4, 1'b0, 32'h0, 1'b1);
      chk("R3 delay slot next_pc", next_pc, TBL[i].after);
      chk("R2 slot taken", {31'b0, taken}, 32'h0);
      tick();
    end

    // R8: call inside the delay slot of a branch
    drive(32'h68000005, 32'h00009000, 1'b0, 32'h0, 1'b1);
    tick();
    drive(32'h6C000010, 32'h00009004, 1'b0, 32'h0, 1'b1);
    chk("R8 slot_xfer", {31'b0, slot_xfer}, 32'h1);
    chk("R8 slot taken", {31'b0, taken}, 32'h0);
    chk("R8 slot link_we", {31'b0, link_we}, 32'h0);
    chk("R8 first target kept", next_pc, 32'h00009018);
    tick();
    drive(NOP, 32'h00009018, 1'b0, 32'h0, 1'b1);
    chk("R8 second not taken", next_pc, 32'h0000901C);
    chk("R8 slot_xfer clears", {31'b0, slot_xfer}, 32'h0);
    tick();

    // R9: stall while a redirect is pending
    drive(32'h68000006, 32'h0000A000, 1'b0, 32'h0, 1'b1);
    tick();
    drive(NOP, 32'h0000A004, 1'b0, 32'h0, 1'b0);
    tick();
    drive(NOP, 32'h0000A004, 1'b0, 32'h0, 1'b0);
    chk("R9 pending held in stall", next_pc, 32'h0000A01C);
    tick();
    drive(NOP, 32'h0000A004, 1'b0, 32'h0, 1'b1);
    chk("R9 pending used after stall", next_pc, 32'h0000A01C);
    tick();
    drive(NOP, 32'h0000A01C, 1'b0, 32'h0, 1'b1);
    chk("R9 sequential after target", next_pc, 32'h0000A020);
    tick();

    // R9: branch word while fetch disabled leaves no redirect
    drive(32'h6C000006, 32'h0000B000, 1'b0, 32'h0, 1'b0);
    chk("R9 no taken when disabled", {31'b0, taken}, 32'h0);
    chk("R9 no link when disabled", {31'b0, link_we}, 32'h0);
    tick();
    drive(NOP, 32'h0000B004, 1'b0, 32'h0, 1'b1);
    chk("R9 disabled branch ignored", next_pc, 32'h0000B008);
    tick();

    // R1: reset while a redirect is pending clears it at once
    drive(32'h68000040, 32'h0000C000, 1'b0, 32'h0, 1'b1);
    tick();
    rst_n = 1'b0;
    drive(NOP, 32'h00000200, 1'b0, 32'h0, 1'b1);
    chk("R1 async reset clears redirect", next_pc, 32'h00000204);
    tick();
    rst_n = 1'b1;
    tick();
    drive(NOP, 32'h00000300, 1'b0, 32'h0, 1'b1);
    chk("R1 sequential after reset", next_pc, 32'h00000304);
    tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule